// File: doc/BRIEF.md
# Per-Interface Doorbell Interrupt Mapper

This block turns notification events from many virtual network interfaces into bits of a single 16-bit host-visible interrupt identifier register. Each interface can raise two kinds of event toward its guest: a send-side completion and a receive-side arrival. An event arrives as a one-cycle pulse on one of several request lanes, tagged with the interface index and the direction. If the guest has enabled that direction for that interface, the register bit assigned to the event is set. Any set bit holds a single level-sensitive master interrupt to the host.

The register has eight send/receive bit pairs. When there are more interfaces than pairs, interfaces fold onto shared pairs by their index modulo eight. The host reads the register to find the group of interfaces and the direction that fired, then writes ones to clear the bits it has handled. Guest-to-device notification is done by polling, so the block has no inbound doorbell path.

Top module: `dbm_doorbell_top`

## Requirements
- R1: After synchronous reset the identifier register reads 0, the master interrupt is low, and every send and receive enable is off. An event pulsed right after reset therefore sets nothing.
- R2: An enabled event from interface i with direction d sets bit 2*(i mod 8)+d. The direction encoding is d=0 for send and d=1 for receive. The bit is visible on `id_reg` in the cycle after the request pulse.
- R3: An event whose direction is disabled for its interface sets no bit. An enable write takes effect for requests in the cycles after the write. A request in the same cycle as the write sees the old enable.
- R4: A host clear (`clr_we`=1) clears exactly the register bits where `clr_mask` is 1. Bits where the mask is 0 keep their value.
- R5: If a set request and a host clear hit the same bit in the same cycle, the bit ends up set.
- R6: Requests on several lanes in the same cycle are all ORed into the register. Interfaces whose indices agree modulo 8 set the same bit.
- R7: The master interrupt `irq` equals the OR of all register bits in every cycle. It goes low only once the register reads 0.
- R8: A set bit stays set until the host clears it. A repeated event on a bit that is already set leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NUM_REQ | One-cycle event pulse, one per request lane |
| req_idx | input | NUM_REQ*IDX_W | Interface index per lane; lane l occupies bits [l*IDX_W +: IDX_W] |
| req_dir | input | NUM_REQ | Event direction per lane: 0 send, 1 receive |
| en_we | input | 1 | Enable write strobe |
| en_idx | input | IDX_W | Interface whose enables are written |
| en_tx | input | 1 | New send-event enable value |
| en_rx | input | 1 | New receive-event enable value |
| clr_we | input | 1 | Host write-ones-to-clear strobe |
| clr_mask | input | REG_W | Bits to clear |
| id_reg | output | REG_W | Interrupt identifier register |
| irq | output | 1 | Master interrupt level |

## Verification
Single-lane events are driven from interfaces at the low and high ends of the index range and in both directions, which confirms the bit mapping and shows whether send and receive are swapped. Two lanes fire in the same cycle from interfaces that share a pair, and a single shared interface fires alone; this separates proper OR merging and modulo folding from a design that drops a lane or maps an index without folding. Enable writes made in the same cycle as a request, and later disables, show when gating takes effect. A clear landing on a bit that is being set in the same cycle, together with partial-mask clears, shows that set has priority and that clearing is confined to the masked bits. Throughout, the master interrupt is compared with the register contents.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  typedef enum logic {
    DIR_SEND = 1'b0,
    DIR_RECV = 1'b1
  } dbm_dir_e;

  // Register bit position for an interface index and direction.
  function automatic int dbm_bit_pos(input int idx, input logic dir, input int pairs);
    return 2 * (idx % pairs) + (dir ? 1 : 0);
  endfunction
endpackage

// File: rtl/dbm_enable_bank.sv
module dbm_enable_bank #(
  parameter int NUM_IF = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              tx_val,
  input  logic              rx_val,
  output logic [NUM_IF-1:0] tx_en,
  output logic [NUM_IF-1:0] rx_en
);
  // Flop bank: every request lane reads it in parallel each cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= '0;
      rx_en <= '0;
    end else if (we && (32'(idx) < NUM_IF)) begin
      tx_en[idx] <= tx_val;
      rx_en[idx] <= rx_val;
    end
  end
endmodule

// File: rtl/dbm_lane_decode.sv
module dbm_lane_decode
  import dbm_pkg::*;
#(
  parameter int NUM_IF = 32,
  parameter int IDX_W  = 5,
  parameter int REG_W  = 16
) (
  input  logic              vld,
  input  logic [IDX_W-1:0]  idx,
  input  logic              dir,
  input  logic [NUM_IF-1:0] tx_en,
  input  logic [NUM_IF-1:0] rx_en,
  output logic [REG_W-1:0]  set_vec
);
  localparam int PAIRS = REG_W / 2;

  logic hit;
  int   pos;

  always_comb begin
    hit = 1'b0;
    if (vld && (32'(idx) < NUM_IF)) begin
      hit = (dir == DIR_RECV) ? rx_en[idx] : tx_en[idx];
    end
    pos = dbm_bit_pos(32'(idx), dir, PAIRS);
    for (int k = 0; k < REG_W; k++) begin
      set_vec[k] = hit && (k == pos);
    end
  end
endmodule

// File: rtl/dbm_status_reg.sv
module dbm_status_reg #(
  parameter int REG_W   = 16,
  parameter int NUM_REQ = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ*REG_W-1:0] set_all,
  input  logic                     clr_we,
  input  logic [REG_W-1:0]         clr_mask,
  output logic [REG_W-1:0]         id_q,
  output logic                     irq_q
);
  logic [REG_W-1:0] set_or;
  logic [REG_W-1:0] nxt;

  always_comb begin
    set_or = '0;
    for (int l = 0; l < NUM_REQ; l++) begin
      set_or = set_or | set_all[l*REG_W +: REG_W];
    end
    // Clear first, then set: a same-cycle set survives.
    nxt = (id_q & ~(clr_we ? clr_mask : '0)) | set_or;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      id_q  <= nxt;
      irq_q <= |nxt;
    end
  end
endmodule

// File: rtl/dbm_doorbell_top.sv
module dbm_doorbell_top #(
  parameter int NUM_IF  = 32,
  parameter int REG_W   = 16,
  parameter int NUM_REQ = 2,
  parameter int IDX_W   = (NUM_IF > 1) ? $clog2(NUM_IF) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       req_vld,
  input  logic [NUM_REQ*IDX_W-1:0] req_idx,
  input  logic [NUM_REQ-1:0]       req_dir,
  input  logic                     en_we,
  input  logic [IDX_W-1:0]         en_idx,
  input  logic                     en_tx,
  input  logic                     en_rx,
  input  logic                     clr_we,
  input  logic [REG_W-1:0]         clr_mask,
  output logic [REG_W-1:0]         id_reg,
  output logic                     irq
);
  logic [NUM_IF-1:0]        tx_en;
  logic [NUM_IF-1:0]        rx_en;
  logic [NUM_REQ*REG_W-1:0] set_all;

  dbm_enable_bank #(.NUM_IF(NUM_IF), .IDX_W(IDX_W)) u_en (
    .clk(clk), .rst(rst), .we(en_we), .idx(en_idx),
    .tx_val(en_tx), .rx_val(en_rx), .tx_en(tx_en), .rx_en(rx_en)
  );

  for (genvar l = 0; l < NUM_REQ; l++) begin : g_lane
    dbm_lane_decode #(.NUM_IF(NUM_IF), .IDX_W(IDX_W), .REG_W(REG_W)) u_dec (
      .vld(req_vld[l]), .idx(req_idx[l*IDX_W +: IDX_W]), .dir(req_dir[l]),
      .tx_en(tx_en), .rx_en(rx_en), .set_vec(set_all[l*REG_W +: REG_W])
    );
  end

  dbm_status_reg #(.REG_W(REG_W), .NUM_REQ(NUM_REQ)) u_st (
    .clk(clk), .rst(rst), .set_all(set_all), .clr_we(clr_we),
    .clr_mask(clr_mask), .id_q(id_reg), .irq_q(irq)
  );
endmodule

// File: rtl/dbm_doorbell_chk.sv
module dbm_doorbell_chk #(
  parameter int REG_W   = 16,
  parameter int NUM_REQ = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req_vld,
  input logic               clr_we,
  input logic [REG_W-1:0]   clr_mask,
  input logic [REG_W-1:0]   id_reg,
  input logic               irq
);
  // R1: reset empties the register and drops the interrupt
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (id_reg == '0 && !irq));

  // R7: master interrupt tracks the OR of the register
  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq == (|id_reg));

  // R3: with no request pulse, no bit can rise
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !(|req_vld) |=> ((id_reg & ~$past(id_reg)) == '0));

  // R8: with no host clear, no bit can fall
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((~id_reg & $past(id_reg)) == '0));

  // R4: a clear with no competing request empties the masked bits
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !(|req_vld)) |=> ((id_reg & $past(clr_mask)) == '0));
endmodule

bind dbm_doorbell_top dbm_doorbell_chk #(.REG_W(REG_W), .NUM_REQ(NUM_REQ)) u_chk (.*);

// File: tb/sim_dbm_doorbell_top.sv
`timescale 1ns/1ps
module sim_dbm_doorbell_top;
  localparam int NUM_IF  = 32;
  localparam int REG_W   = 16;
  localparam int NUM_REQ = 2;
  localparam int IDX_W   = 5;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [NUM_REQ-1:0]       req_vld = '0;
  logic [NUM_REQ*IDX_W-1:0] req_idx = '0;
  logic [NUM_REQ-1:0]       req_dir = '0;
  logic                     en_we = 1'b0;
  logic [IDX_W-1:0]         en_idx = '0;
  logic                     en_tx = 1'b0;
  logic                     en_rx = 1'b0;
  logic                     clr_we = 1'b0;
  logic [REG_W-1:0]         clr_mask = '0;
  logic [REG_W-1:0]         id_reg;
  logic                     irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dbm_doorbell_top #(.NUM_IF(NUM_IF), .REG_W(REG_W), .NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [REG_W-1:0] got, input logic [REG_W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_en(input int idx, input logic tx, input logic rx);
    en_we = 1'b1; en_idx = IDX_W'(idx); en_tx = tx; en_rx = rx;
    tick();
    en_we = 1'b0;
  endtask

  task automatic pulse1(input int idx, input logic dir);
    req_vld[0] = 1'b1; req_idx[0 +: IDX_W] = IDX_W'(idx); req_dir[0] = dir;
    tick();
    req_vld = '0;
  endtask

  task automatic clr(input logic [REG_W-1:0] m);
    clr_we = 1'b1; clr_mask = m;
    tick();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset();
    chk("R1 reg after reset", id_reg, 16'h0000);
    chk("R1 irq after reset", {15'd0, irq}, 16'h0000);
    pulse1(4, 1'b0);
    chk("R1 enables off after reset", id_reg, 16'h0000);
  endtask

  task automatic t_gate();
    set_en(5, 1'b1, 1'b0);
    pulse1(5, 1'b1);
    chk("R3 disabled receive ignored", id_reg, 16'h0000);
    pulse1(5, 1'b0);
    chk("R2 if5 send -> bit10", id_reg, 16'h0400);
    chk("R7 irq high", {15'd0, irq}, 16'h0001);
    clr(16'hFFFF);
    chk("R7 irq low when empty", {15'd0, irq}, 16'h0000);
    // enable write and request in the same cycle: old enable used
    en_we = 1'b1; en_idx = 5'd6; en_tx = 1'b1; en_rx = 1'b0;
    req_vld[0] = 1'b1; req_idx[0 +: IDX_W] = 5'd6; req_dir[0] = 1'b0;
    tick();
    en_we = 1'b0; req_vld = '0;
    chk("R3 same-cycle enable not yet effective", id_reg, 16'h0000);
    pulse1(6, 1'b0);
    chk("R3 enable effective next cycle", id_reg, 16'h1000);
    clr(16'hFFFF);
    set_en(6, 1'b0, 1'b0);
    pulse1(6, 1'b0);
    chk("R3 disabled send ignored", id_reg, 16'h0000);
  endtask

  task automatic t_map();
    set_en(31, 1'b1, 1'b1);
    pulse1(31, 1'b1);
    chk("R2 if31 receive -> bit15", id_reg, 16'h8000);
    set_en(0, 1'b1, 1'b1);
    pulse1(0, 1'b0);
    chk("R2 if0 send -> bit0", id_reg, 16'h8001);
    clr(16'hFFFF);
  endtask

  task automatic t_share();
    set_en(2, 1'b1, 1'b0);
    set_en(10, 1'b1, 1'b0);
    set_en(18, 1'b0, 1'b1);
    req_vld = 2'b11;
    req_idx[0 +: IDX_W] = 5'd10;     req_dir[0] = 1'b0;
    req_idx[IDX_W +: IDX_W] = 5'd18; req_dir[1] = 1'b1;
    tick();
    req_vld = '0;
    chk("R6 two lanes ORed", id_reg, 16'h0030);
    clr(16'hFFFF);
    pulse1(2, 1'b0);
    chk("R6 if2 shares bit4 with if10", id_reg, 16'h0010);
  endtask

  task automatic t_sticky();
    tick(); tick(); tick();
    chk("R8 bit holds while idle", id_reg, 16'h0010);
    pulse1(2, 1'b0);
    chk("R8 repeated event no change", id_reg, 16'h0010);
  endtask

  task automatic t_clear();
    pulse1(31, 1'b1);
    chk("R6 second bit added", id_reg, 16'h8010);
    clr(16'h0010);
    chk("R4 partial clear", id_reg, 16'h8000);
    chk("R7 irq stays high", {15'd0, irq}, 16'h0001);
    clr(16'h0000);
    chk("R4 zero mask clears nothing", id_reg, 16'h8000);
  endtask

  task automatic t_collide();
    pulse1(0, 1'b0);
    chk("R2 bit0 set again", id_reg, 16'h8001);
    clr_we = 1'b1; clr_mask = 16'h8001;
    req_vld[0] = 1'b1; req_idx[0 +: IDX_W] = 5'd0; req_dir[0] = 1'b0;
    tick();
    clr_we = 1'b0; clr_mask = '0; req_vld = '0;
    chk("R5 set wins over clear", id_reg, 16'h0001);
    chk("R7 irq high after collision", {15'd0, irq}, 16'h0001);
    clr(16'h0001);
    chk("R4 final clear", id_reg, 16'h0000);
    chk("R7 irq low at zero", {15'd0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_gate();
    t_map();
    t_share();
    t_sticky();
    t_clear();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule